// File: doc/BRIEF.md
# Card Command Issue and Response Capture Unit

This unit launches one command toward a memory card and records what comes back. A host loads a 32-bit argument register, then writes an 11-bit command word. If that write has its enable bit set and its pending bit clear, the unit presents the 6-bit command index and the stored argument on a card-side request port for one cycle. It then gathers reply bytes from the card until the card ends the reply, reports an error, or a cycle budget runs out.

The unit counts the reply bytes and checks the count against the response type the command word asks for. A good reply is packed into four 32-bit response words, each built big-endian from consecutive bytes. The outcome is exactly one of three completion flags: sent, response-end or timeout. The enable bit of the command word clears once the command has been handled, and a one-cycle completion pulse lets a data engine take its turn.

The controller has four states. `CS_IDLE` accepts command writes. A launching write moves it to `CS_ISSUE`, which drives the request for one cycle and goes to `CS_WAIT`. `CS_WAIT` collects bytes. It leaves for `CS_FINISH` on reply end, on card error or when the budget expires. `CS_FINISH` records the verdict and returns to `CS_IDLE`. A write with the pending bit set, or with enable clear, stays in `CS_IDLE`.

Top module: `cmd_resp_unit`

## Requirements
- R1: After reset the status flags, the response words and the command readback are all zero, and busy and req_valid are low.
- R2: A command write made while idle, with bit 10 (enable) set and bit 9 (pending) clear, raises req_valid for exactly one cycle. During that cycle req_index carries bits 5:0 of the command word and req_arg carries the last value written to the argument register.
- R3: If bit 6 (response expected) is clear and the card ends the reply without error, the only status flag set is bit 7 (sent), and the response words keep their previous values.
- R4: If bit 6 is set, bit 7 of the command word (long) is clear and the reply has 4 bytes, response word 0 (rsp_words bits 31:0) holds the bytes with the first received byte in bits 31:24. Words 1 to 3 become zero and status bit 6 (response-end) is set.
- R5: A 16-byte reply to a command with bit 6 set is stored as four words, whether or not bit 7 is set. Word k sits at rsp_words bits 32k+31:32k and holds bytes 4k to 4k+3, big-endian. Bit 0 of word 3 is forced to zero, and status bit 6 is set.
- R6: If bit 6 is set and the reply has 0 bytes, or has 4 bytes with bit 7 set, or has any count other than 4 or 16, status bit 2 (timeout) is set and the response words are unchanged.
- R7: A card error, or no reply end within TIMEOUT_CYC cycles of waiting, sets status bit 2 and leaves the response words unchanged.
- R8: A command write with both enable and pending set issues no request. It reads back with bit 10 clear and its other bits as written, and it leaves the status flags unchanged.
- R9: Bit 10 of the command readback is 1 while a launched command is busy. It is 0 when cmd_done pulses. cmd_done lasts one cycle, and exactly one status flag is set at that time.
- R10: Bit 8 (interrupt mode) of the command word has no effect: a command with it set runs exactly like one without it.
- R11: Command writes made while busy are ignored: they neither change the command readback nor start a second command.
- R12: The status flags read zero from the cycle after a launching write until the command completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 11 | Command word: index 5:0, response 6, long 7, interrupt 8, pending 9, enable 10 |
| arg_wr | input | 1 | Argument register write strobe |
| arg_wdata | input | ARG_W | Argument value |
| cmd_rd | output | 11 | Command register readback |
| req_valid | output | 1 | One-cycle command request to the card side |
| req_index | output | 6 | Command index of the request |
| req_arg | output | ARG_W | Argument of the request |
| rsp_byte_vld | input | 1 | Reply byte valid |
| rsp_byte | input | 8 | Reply byte, in order of arrival |
| rsp_done | input | 1 | Card has ended the reply |
| rsp_err | input | 1 | Card reports a failed command |
| rsp_words | output | 4*WORD_W | Response words, word k at bits 32k+31:32k |
| stat_flags | output | 8 | Completion flags: bit 2 timeout, bit 6 response-end, bit 7 sent |
| busy | output | 1 | A command is in flight |
| cmd_done | output | 1 | One-cycle completion pulse, also the data engine's turn |

## Verification
The in-RTL assertions check on every cycle that a request lasts one cycle and that a pending write never produces one. They also check that completion shows exactly one flag with the enable bit already clear, that a short reply zeroes the upper words, and that a long reply never keeps bit 0 of word 3. Only the bench scenarios can show that the stored words match the exact byte order that was sent. The same holds for the length rules that separate valid from invalid replies, for budget expiry when the card stays silent, for writes made while busy being dropped, and for the interrupt bit being ignored.

// File: rtl/cmdrsp_pkg.sv
package cmdrsp_pkg;
    localparam int CMD_W        = 11;
    localparam int IDX_W        = 6;
    localparam int CMD_RSP_BIT  = 6;
    localparam int CMD_LONG_BIT = 7;
    localparam int CMD_IRQ_BIT  = 8;
    localparam int CMD_PEND_BIT = 9;
    localparam int CMD_EN_BIT   = 10;
    localparam int STAT_W       = 8;
    localparam int ST_TIMEOUT   = 2;
    localparam int ST_RESPEND   = 6;
    localparam int ST_SENT      = 7;

    typedef enum logic [1:0] {
        CS_IDLE,
        CS_ISSUE,
        CS_WAIT,
        CS_FINISH
    } cs_state_t;
endpackage

// File: rtl/rsp_assembler.sv
module rsp_assembler #(
    parameter int BYTES = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         vld,
    input  logic [7:0]                   din,
    output logic [BYTES*8-1:0]           sh_out,
    output logic [$clog2(BYTES+2)-1:0]   cnt_out
);
    localparam int SH_W = BYTES * 8;
    localparam int CW   = $clog2(BYTES + 2);

    logic [SH_W-1:0] sh_q;
    logic [CW-1:0]   cnt_q;

    // Shift in bytes; the count saturates one past BYTES to mark an oversize reply.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (vld) begin
            sh_q <= {sh_q[SH_W-9:0], din};
            if (cnt_q != CW'(BYTES + 1)) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign sh_out  = sh_q;
    assign cnt_out = cnt_q;
endmodule

// File: rtl/rsp_watchdog.sv
module rsp_watchdog #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int WW = $clog2(LIMIT + 1);

    logic [WW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (cnt_q != WW'(LIMIT - 1)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run && (cnt_q == WW'(LIMIT - 1));
endmodule

// File: rtl/cmd_resp_unit.sv
module cmd_resp_unit
    import cmdrsp_pkg::*;
#(
    parameter int ARG_W       = 32,
    parameter int WORD_W      = 32,
    parameter int RSP_BYTES   = 16,
    parameter int TIMEOUT_CYC = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmd_wr,
    input  logic [CMD_W-1:0]          cmd_wdata,
    input  logic                      arg_wr,
    input  logic [ARG_W-1:0]          arg_wdata,
    output logic [CMD_W-1:0]          cmd_rd,
    output logic                      req_valid,
    output logic [IDX_W-1:0]          req_index,
    output logic [ARG_W-1:0]          req_arg,
    input  logic                      rsp_byte_vld,
    input  logic [7:0]                rsp_byte,
    input  logic                      rsp_done,
    input  logic                      rsp_err,
    output logic [RSP_BYTES*8-1:0]    rsp_words,
    output logic [STAT_W-1:0]         stat_flags,
    output logic                      busy,
    output logic                      cmd_done
);
    localparam int SH_W        = RSP_BYTES * 8;
    localparam int NWORDS      = SH_W / WORD_W;
    localparam int CW          = $clog2(RSP_BYTES + 2);
    localparam int SHORT_BYTES = WORD_W / 8;

    cs_state_t          st_q, st_d;
    logic [CMD_W-1:0]   cmd_q;
    logic [ARG_W-1:0]   arg_q, arg_launch_q;
    logic               err_q;
    logic [SH_W-1:0]    words_q;
    logic [STAT_W-1:0]  stat_q;
    logic               done_q;

    logic [SH_W-1:0]    sh;
    logic [CW-1:0]      cnt;
    logic               wd_exp;
    logic               launch;
    logic               reply_end;

    logic [SH_W-1:0]    long_words, short_words, words_n;
    logic [STAT_W-1:0]  stat_n;
    logic               store_n;
    logic               len_ok;

    rsp_assembler #(.BYTES(RSP_BYTES)) u_asm (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (st_q == CS_ISSUE),
        .vld     (rsp_byte_vld && (st_q == CS_WAIT)),
        .din     (rsp_byte),
        .sh_out  (sh),
        .cnt_out (cnt)
    );

    rsp_watchdog #(.LIMIT(TIMEOUT_CYC)) u_wd (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (st_q == CS_WAIT),
        .expired (wd_exp)
    );

    assign launch = (st_q == CS_IDLE) && cmd_wr && cmd_wdata[CMD_EN_BIT]
                    && !cmd_wdata[CMD_PEND_BIT];
    assign reply_end = rsp_done || rsp_err || wd_exp;

    // Long layout: earliest bytes land in word 0; last word drops its bit 0.
    for (genvar k = 0; k < NWORDS; k++) begin : g_word
        if (k == NWORDS - 1) begin : g_last
            assign long_words[k*WORD_W +: WORD_W] =
                sh[(NWORDS-1-k)*WORD_W +: WORD_W] & ~WORD_W'(1);
        end else begin : g_mid
            assign long_words[k*WORD_W +: WORD_W] = sh[(NWORDS-1-k)*WORD_W +: WORD_W];
        end
    end
    assign short_words = {{(SH_W-WORD_W){1'b0}}, sh[WORD_W-1:0]};

    // Verdict on the collected reply.
    always_comb begin
        len_ok  = (cnt == CW'(RSP_BYTES)) ||
                  ((cnt == CW'(SHORT_BYTES)) && !cmd_q[CMD_LONG_BIT]);
        stat_n  = '0;
        store_n = 1'b0;
        words_n = (cnt == CW'(RSP_BYTES)) ? long_words : short_words;
        if (err_q) begin
            stat_n[ST_TIMEOUT] = 1'b1;
        end else if (!cmd_q[CMD_RSP_BIT]) begin
            stat_n[ST_SENT] = 1'b1;
        end else if (len_ok) begin
            stat_n[ST_RESPEND] = 1'b1;
            store_n            = 1'b1;
        end else begin
            stat_n[ST_TIMEOUT] = 1'b1;
        end
    end

    // Next-state logic.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CS_IDLE:   if (launch)    st_d = CS_ISSUE;
            CS_ISSUE:                 st_d = CS_WAIT;
            CS_WAIT:   if (reply_end) st_d = CS_FINISH;
            CS_FINISH:                st_d = CS_IDLE;
            default:                  st_d = CS_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CS_IDLE;
        else        st_q <= st_d;
    end

    // Registered outputs and datapath.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q        <= '0;
            arg_q        <= '0;
            arg_launch_q <= '0;
            err_q        <= 1'b0;
            words_q      <= '0;
            stat_q       <= '0;
            done_q       <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (arg_wr) arg_q <= arg_wdata;
            if (st_q == CS_IDLE && cmd_wr) begin
                cmd_q <= cmd_wdata;
                if (cmd_wdata[CMD_PEND_BIT]) cmd_q[CMD_EN_BIT] <= 1'b0;
            end
            if (launch) begin
                arg_launch_q <= arg_q;
                stat_q       <= '0;
            end
            unique case (st_q)
                CS_ISSUE: err_q <= 1'b0;
                CS_WAIT:  if (rsp_err || wd_exp) err_q <= 1'b1;
                CS_FINISH: begin
                    stat_q            <= stat_n;
                    if (store_n) words_q <= words_n;
                    cmd_q[CMD_EN_BIT] <= 1'b0;
                    done_q            <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign cmd_rd     = cmd_q;
    assign req_valid  = (st_q == CS_ISSUE);
    assign req_index  = cmd_q[IDX_W-1:0];
    assign req_arg    = arg_launch_q;
    assign rsp_words  = words_q;
    assign stat_flags = stat_q;
    assign busy       = (st_q != CS_IDLE);
    assign cmd_done   = done_q;

    // R2: a request is a single-cycle pulse
    assert_req_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);

    // R8: a pending write never produces a request
    assert_pending_noissue_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_wr && cmd_wdata[CMD_EN_BIT] && cmd_wdata[CMD_PEND_BIT]) |=> !req_valid);

    // R9: exactly one flag and enable cleared at completion
    assert_one_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> ($countones(stat_flags) == 1) && !cmd_rd[CMD_EN_BIT]);

    // R9: completion pulse lasts one cycle
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_done);

    // R4: short reply clears the upper words
    assert_short_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && stat_flags[ST_RESPEND] && cnt == CW'(SHORT_BYTES))
        |-> (rsp_words[SH_W-1:WORD_W] == '0));

    // R5: last word of a long reply has bit 0 clear
    assert_long_lsb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && stat_flags[ST_RESPEND] && cnt == CW'(RSP_BYTES))
        |-> !rsp_words[(NWORDS-1)*WORD_W]);

    // R12: no flag is visible while a command is in flight
    assert_flags_clear_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && st_q != CS_IDLE && $past(launch)) |-> (stat_flags == '0));
endmodule

// File: tb/sim_cmd_resp_unit.sv
module sim_cmd_resp_unit;
    import cmdrsp_pkg::*;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_wr = 1'b0;
    logic [10:0]  cmd_wdata = '0;
    logic         arg_wr = 1'b0;
    logic [31:0]  arg_wdata = '0;
    logic [10:0]  cmd_rd;
    logic         req_valid;
    logic [5:0]   req_index;
    logic [31:0]  req_arg;
    logic         rsp_byte_vld = 1'b0;
    logic [7:0]   rsp_byte = '0;
    logic         rsp_done = 1'b0;
    logic         rsp_err = 1'b0;
    logic [127:0] rsp_words;
    logic [7:0]   stat_flags;
    logic         busy;
    logic         cmd_done;

    always #4 clk = ~clk;

    cmd_resp_unit u0 (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .arg_wr(arg_wr), .arg_wdata(arg_wdata), .cmd_rd(cmd_rd),
        .req_valid(req_valid), .req_index(req_index), .req_arg(req_arg),
        .rsp_byte_vld(rsp_byte_vld), .rsp_byte(rsp_byte), .rsp_done(rsp_done),
        .rsp_err(rsp_err), .rsp_words(rsp_words), .stat_flags(stat_flags),
        .busy(busy), .cmd_done(cmd_done)
    );

    typedef struct {
        string        tag;
        logic [7:0]   stat;
        logic [127:0] words;
    } exp_t;

    exp_t         sb[$];
    logic [7:0]   bq[$];
    logic [127:0] model_words = '0;
    logic [7:0]   last_stat = '0;
    int           n_chk = 0;
    int           n_fail = 0;
    bit           finished = 1'b0;

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pop the expected result on each completion pulse.
    always @(negedge clk) begin
        if (rst_n && cmd_done) begin
            if (sb.size() == 0) begin
                chk("R9 unexpected completion", 128'd1, 128'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk({e.tag, " status"}, 128'(stat_flags), 128'(e.stat));
                chk({e.tag, " words"}, rsp_words, e.words);
                chk("R9 enable clear at done", 128'(cmd_rd[10]), 128'd0);
                last_stat = stat_flags;
            end
        end
    end

    // Driver: predicts the outcome, then runs one command with the card model.
    // mode 0: card ends reply, 1: card error, 2: card silent
    task automatic issue(input logic [10:0] cw, input logic [31:0] a, input int mode,
                         input bit poke, input string tag);
        exp_t e;
        int   n;
        int   guard;
        n = bq.size();
        e.tag = tag;
        e.words = model_words;
        if (mode != 0) begin
            e.stat = 8'h04;
        end else if (!cw[6]) begin
            e.stat = 8'h80;
        end else if (n == 16 || (n == 4 && !cw[7])) begin
            e.stat = 8'h40;
            if (n == 16) begin
                for (int k = 0; k < 4; k++)
                    e.words[32*k +: 32] = {bq[4*k], bq[4*k+1], bq[4*k+2], bq[4*k+3]};
                e.words[96] = 1'b0;
            end else begin
                e.words = {96'd0, bq[0], bq[1], bq[2], bq[3]};
            end
            model_words = e.words;
        end else begin
            e.stat = 8'h04;
        end
        sb.push_back(e);

        @(negedge clk); arg_wr = 1'b1; arg_wdata = a;
        @(negedge clk); arg_wr = 1'b0; cmd_wr = 1'b1; cmd_wdata = cw;
        @(negedge clk); cmd_wr = 1'b0;
        chk("R2 request valid", 128'(req_valid), 128'd1);
        chk("R2 request index", 128'(req_index), 128'(cw[5:0]));
        chk("R2 request argument", 128'(req_arg), 128'(a));
        chk("R12 flags clear on issue", 128'(stat_flags), 128'd0);
        chk("R9 enable set while busy", 128'({busy, cmd_rd[10]}), 128'd3);
        @(negedge clk);
        if (poke) begin
            cmd_wr = 1'b1; cmd_wdata = 11'h43F;
            @(negedge clk); cmd_wr = 1'b0;
        end
        for (int k = 0; k < n; k++) begin
            rsp_byte_vld = 1'b1; rsp_byte = bq[k];
            @(negedge clk);
        end
        rsp_byte_vld = 1'b0;
        if (mode == 0) begin
            rsp_done = 1'b1; @(negedge clk); rsp_done = 1'b0;
        end else if (mode == 1) begin
            rsp_err = 1'b1; @(negedge clk); rsp_err = 1'b0;
        end
        guard = 0;
        while (busy && guard < 500) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        if (poke) chk("R11 busy write ignored", 128'(cmd_rd), 128'(cw & ~11'h400));
    endtask

    task automatic fill(input int n, input logic [7:0] base);
        bq.delete();
        for (int k = 0; k < n; k++) bq.push_back(base + 8'(k));
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset flags", 128'(stat_flags), 128'd0);
        chk("R1 reset words", rsp_words, 128'd0);
        chk("R1 reset readback", 128'(cmd_rd), 128'd0);
        chk("R1 reset busy/req", 128'({busy, req_valid}), 128'd0);

        bq.delete();
        issue(11'h402, 32'h0000_0000, 0, 1'b0, "R3 no response");
        fill(4, 8'h12);
        bq[0] = 8'h12; bq[1] = 8'h34; bq[2] = 8'h56; bq[3] = 8'h78;
        issue(11'h451, 32'hCAFE_0001, 0, 1'b0, "R4 short reply");
        fill(4, 8'h60);
        issue(11'h402, 32'h0000_0002, 0, 1'b0, "R3 bytes ignored without response");
        fill(16, 8'hA0);
        issue(11'h4C2, 32'h1234_5678, 0, 1'b0, "R5 long reply");
        fill(16, 8'h31);
        issue(11'h449, 32'h0BAD_F00D, 0, 1'b0, "R5 16 bytes on short request");
        fill(4, 8'h77);
        issue(11'h4C9, 32'h0000_0003, 0, 1'b0, "R6 4 bytes on long request");
        bq.delete();
        issue(11'h448, 32'h0000_0004, 0, 1'b0, "R6 zero bytes");
        fill(5, 8'h10);
        issue(11'h448, 32'h0000_0005, 0, 1'b0, "R6 five bytes");
        fill(17, 8'h20);
        issue(11'h4C8, 32'h0000_0006, 0, 1'b0, "R6 seventeen bytes");
        fill(4, 8'h90);
        issue(11'h448, 32'h0000_0007, 1, 1'b0, "R7 card error");
        bq.delete();
        issue(11'h448, 32'h0000_0008, 2, 1'b0, "R7 silent card");
        fill(4, 8'hC4);
        issue(11'h555, 32'hFEED_BEEF, 0, 1'b0, "R10 interrupt bit ignored");
        fill(4, 8'h44);
        issue(11'h44A, 32'h0000_0009, 0, 1'b1, "R11 command during busy");

        // R8: pending write issues nothing.
        begin
            bit seen = 1'b0;
            @(negedge clk); cmd_wr = 1'b1; cmd_wdata = 11'h645;
            for (int k = 0; k < 10; k++) begin
                @(negedge clk);
                cmd_wr = 1'b0;
                if (req_valid || busy) seen = 1'b1;
            end
            chk("R8 no request when pending", 128'(seen), 128'd0);
            chk("R8 readback enable cleared", 128'(cmd_rd), 128'(11'h245));
            chk("R8 flags unchanged", 128'(stat_flags), 128'(last_stat));
        end

        repeat (3) @(negedge clk);
        chk("R9 every completion seen", 128'(sb.size()), 128'd0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule